// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An eight-pin general-purpose I/O port controller sitting behind a small register bus. Each pin can be driven in push-pull fashion from one data register, or in open-drain fashion from a second data register. A per-pin mode bit chooses between the two. A separate per-pin bit enables a weak pull-up, and the polarity of that bit is active low. The block does not model the analog pad. It drives three enable vectors toward a pad model: drive-high, drive-low and pull-up. The pad levels come back through a two-flop synchronizer.

Software writes registers through an address, a write strobe and write data. Reading the data address returns the synchronized pin levels. Reading any other address returns the stored value of that register. To use a pin as an input, clear its mode bit and set its open-drain bit. This is also the state the port takes after reset: every pin is released, and every pull-up is enabled.

Top module: `gpio_port`

## Requirements
- R1: After reset the registers hold: push-pull data 0xFF, mode 0x00, pull-up control 0x00 and open-drain data 0xFF. As a result drv_hi_o=0x00, drv_lo_o=0x00 and pu_en_o=0xFF.
- R2: A pin whose mode bit is 0 never has its high driver enabled, whatever its push-pull data bit holds.
- R3: A pin whose mode bit is 1 follows its push-pull data bit. A data bit of 1 enables only the high driver. A data bit of 0 enables only the low driver. The pin's open-drain data bit has no effect in this mode.
- R4: A pin whose mode bit is 0 follows its open-drain data bit. A bit of 0 enables the low driver. A bit of 1 leaves both drivers off.
- R5: The pull-up enable of a pin is the inverse of its pull-up control bit, in either mode.
- R6: For every pin and every register combination, drv_hi_o and drv_lo_o are never both 1.
- R7: A write with we_i=1 updates the addressed register on that rising clock edge, and the outputs change only after that edge. Address map: 0 is push-pull data, 1 is mode, 2 is pull-up control, 3 is open-drain data. With we_i=0 no register changes.
- R8: A read of address 0 returns pad_i as it was two rising edges earlier, taken through a two-flop synchronizer. It does not return the push-pull data register.
- R9: Reads of addresses 1, 2 and 3 return the stored mode, pull-up control and open-drain data registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pad_i | input | 8 | Pad input levels |
| drv_hi_o | output | 8 | Per-pin high driver enable |
| drv_lo_o | output | 8 | Per-pin low driver enable |
| pu_en_o | output | 8 | Per-pin weak pull-up enable |

## Verification
Two functions can land in the same cycle: a register write that changes a pin's drivers, and the synchronizer sampling a new pad level. The bench changes pad_i while it is writing the mode and open-drain registers. It then checks that address 0 still shows the pad levels after exactly two edges, and that the drivers reflect the write from the edge that carried the strobe. Driver exclusivity is judged separately. The bench rotates all eight mode, push-pull and open-drain combinations across all eight pins, so that every pin sees every combination.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_DATA = 2'd0,
    REG_MODE = 2'd1,
    REG_PULL = 2'd2,
    REG_OPEN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [WIDTH-1:0]      wdata_i,
  output logic [WIDTH-1:0]      pp_q_o,
  output logic [WIDTH-1:0]      mode_q_o,
  output logic [WIDTH-1:0]      pull_n_q_o,
  output logic [WIDTH-1:0]      od_q_o
);
  localparam logic [WIDTH-1:0] ONES  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZEROS = {WIDTH{1'b0}};

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_q_o     <= ONES;
      mode_q_o   <= ZEROS;
      pull_n_q_o <= ZEROS;
      od_q_o     <= ONES;
    end else if (we_i) begin
      unique case (sel)
        REG_DATA: pp_q_o     <= wdata_i;
        REG_MODE: mode_q_o   <= wdata_i;
        REG_PULL: pull_n_q_o <= wdata_i;
        REG_OPEN: od_q_o     <= wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] pp_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] pull_n_i,
  input  logic [WIDTH-1:0] od_i,
  output logic [WIDTH-1:0] drv_hi_o,
  output logic [WIDTH-1:0] drv_lo_o,
  output logic [WIDTH-1:0] pu_en_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      if (mode_i[i]) begin
        // push-pull: exactly one driver on
        drv_hi_o[i] = pp_i[i];
        drv_lo_o[i] = ~pp_i[i];
      end else begin
        // open-drain: high driver always off
        drv_hi_o[i] = 1'b0;
        drv_lo_o[i] = ~od_i[i];
      end
      pu_en_o[i] = ~pull_n_i[i];
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  drv_hi_o,
  output logic [WIDTH-1:0]  drv_lo_o,
  output logic [WIDTH-1:0]  pu_en_o
);
  logic [WIDTH-1:0] pp_q, mode_q, pull_n_q, od_q, pad_sync;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .pp_q_o     (pp_q),
    .mode_q_o   (mode_q),
    .pull_n_q_o (pull_n_q),
    .od_q_o     (od_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .pp_i     (pp_q),
    .mode_i   (mode_q),
    .pull_n_i (pull_n_q),
    .od_i     (od_q),
    .drv_hi_o (drv_hi_o),
    .drv_lo_o (drv_lo_o),
    .pu_en_o  (pu_en_o)
  );

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_DATA: rdata_o = pad_sync;
      REG_MODE: rdata_o = mode_q;
      REG_PULL: rdata_o = pull_n_q;
      REG_OPEN: rdata_o = od_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pad_i,
  input logic [WIDTH-1:0]  drv_hi_o,
  input logic [WIDTH-1:0]  drv_lo_o,
  input logic [WIDTH-1:0]  pu_en_o,
  input logic [WIDTH-1:0]  mode_q,
  input logic [WIDTH-1:0]  od_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_hi_o & drv_lo_o) == '0);

  p_od_no_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_hi_o & ~mode_q) == '0);

  p_wr_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_MODE) |=> mode_q == $past(wdata_i));

  p_no_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mode_q) && $stable(od_q)));

  p_pull_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_PULL) |=> pu_en_o == ~$past(wdata_i));

  p_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && addr_i == REG_DATA) |-> rdata_o == $past(pad_i, 2));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pad_i    (pad_i),
  .drv_hi_o (drv_hi_o),
  .drv_lo_o (drv_lo_o),
  .pu_en_o  (pu_en_o),
  .mode_q   (mode_q),
  .od_q     (od_q)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [7:0] pad_i = 8'h00;
  logic [7:0] drv_hi_o, drv_lo_o, pu_en_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_i(pad_i),
    .drv_hi_o(drv_hi_o), .drv_lo_o(drv_lo_o), .pu_en_o(pu_en_o)
  );

  // {mode, pp, od, pull_ctrl, exp_hi, exp_lo, exp_pu}
  localparam logic [55:0] VEC [6] = '{
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'hFF, 8'hA5, 8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h00},
    {8'h00, 8'h00, 8'h0F, 8'hF0, 8'h00, 8'hF0, 8'h0F},
    {8'hF0, 8'h3C, 8'h55, 8'h81, 8'h30, 8'hCA, 8'h7E},
    {8'h0F, 8'h0F, 8'h0F, 8'hAA, 8'h0F, 8'hF0, 8'h55},
    {8'h33, 8'h11, 8'h44, 8'h00, 8'h11, 8'hAA, 8'hFF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk_i);
      cycles++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    // R1 reset state
    #12;
    chk("R1 hi in reset", drv_hi_o, 8'h00);
    chk("R1 lo in reset", drv_lo_o, 8'h00);
    chk("R1 pu in reset", pu_en_o, 8'hFF);
    @(negedge clk_i); rst_ni = 1'b1;
    rd(2'd1, r); chk("R1 mode reset", r, 8'h00);
    rd(2'd2, r); chk("R1 pull reset", r, 8'h00);
    rd(2'd3, r); chk("R1 od reset", r, 8'hFF);
    // push-pull reset value 0xFF seen through drivers in push-pull mode
    wr(2'd1, 8'hFF);
    chk("R1 pp reset via drivers", drv_hi_o, 8'hFF);
    wr(2'd1, 8'h00);

    // vector table: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      wr(2'd1, VEC[v][55:48]);
      wr(2'd0, VEC[v][47:40]);
      wr(2'd3, VEC[v][39:32]);
      wr(2'd2, VEC[v][31:24]);
      chk($sformatf("R3 R2 hi vec%0d", v), drv_hi_o, VEC[v][23:16]);
      chk($sformatf("R4 R3 lo vec%0d", v), drv_lo_o, VEC[v][15:8]);
      chk($sformatf("R5 pu vec%0d", v), pu_en_o, VEC[v][7:0]);
      chk($sformatf("R6 excl vec%0d", v), drv_hi_o & drv_lo_o, 8'h00);
      rd(2'd1, r); chk($sformatf("R9 mode rb vec%0d", v), r, VEC[v][55:48]);
      rd(2'd2, r); chk($sformatf("R9 pull rb vec%0d", v), r, VEC[v][31:24]);
      rd(2'd3, r); chk($sformatf("R9 od rb vec%0d", v), r, VEC[v][39:32]);
    end

    // R6 exhaustive: each pin sees each {mode,pp,od} combination
    for (int rot = 0; rot < 8; rot++) begin
      logic [7:0] m, p, o, eh, el;
      for (int i = 0; i < 8; i++) begin
        int c;
        c = (i + rot) % 8;
        m[i] = c[2]; p[i] = c[1]; o[i] = c[0];
        eh[i] = c[2] & c[1];
        el[i] = c[2] ? ~c[1] : ~c[0];
      end
      wr(2'd1, m); wr(2'd0, p); wr(2'd3, o);
      chk($sformatf("R6 excl rot%0d", rot), drv_hi_o & drv_lo_o, 8'h00);
      chk($sformatf("R3 R4 hi rot%0d", rot), drv_hi_o, eh);
      chk($sformatf("R3 R4 lo rot%0d", rot), drv_lo_o, el);
    end

    // R7 write timing and strobe low
    wr(2'd1, 8'h00); wr(2'd3, 8'hFF);
    @(negedge clk_i);
    addr_i = 2'd3; wdata_i = 8'h00; we_i = 1'b1;
    #1 chk("R7 before edge", drv_lo_o, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    we_i = 1'b0;
    chk("R7 after edge", drv_lo_o, 8'hFF);
    @(negedge clk_i);
    addr_i = 2'd3; wdata_i = 8'hFF; we_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk("R7 no strobe drivers", drv_lo_o, 8'hFF);
    rd(2'd3, r); chk("R7 no strobe readback", r, 8'h00);

    // R8 sync latency, with concurrent register writes
    rd(2'd0, r);
    @(negedge clk_i);
    addr_i = 2'd1; wdata_i = 8'hFF; we_i = 1'b1; pad_i = 8'h96;
    @(posedge clk_i); @(negedge clk_i);
    addr_i = 2'd0; we_i = 1'b0;
    #1 chk("R8 one edge old", rdata_o, 8'h00);
    chk("R7 concurrent write", drv_hi_o & drv_lo_o, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    chk("R8 two edges new", rdata_o, 8'h96);
    wr(2'd0, 8'h0F);
    rd(2'd0, r); chk("R8 pad not pp data", r, 8'h96);
    chk("R3 pp write", drv_hi_o, 8'h0F);

    // R1 mid-run reset
    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk("R1 re-reset lo", drv_lo_o, 8'h00);
    chk("R1 re-reset hi", drv_hi_o, 8'h00);
    chk("R1 re-reset pu", pu_en_o, 8'hFF);
    @(negedge clk_i); rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule